// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes complete incoming frames and stores each one in system memory through descriptor rings that software has prepared. Software builds up to four circular rings of descriptors and programs a pointer to each ring through a 32-bit register port. When a frame arrives, its length comes first on a length handshake and its bytes follow on a byte stream. The engine then walks the rings in a fixed order. It looks for a descriptor that software has handed over and whose buffer is large enough for the frame.

When such a descriptor is found, the engine writes the frame bytes into its buffer, or two bytes further in if the alignment offset is enabled. It records the stored byte count, clears the ownership flag and moves that ring's working pointer to the next descriptor. It then sets the receive cause bit, which drives a level interrupt through a mask. A frame that fits nowhere is still read from the stream and thrown away, so the input never waits forever. All memory traffic goes through a simple request/acknowledge master that makes single word or single byte accesses.

Top module: `rxring_dma`

## Requirements
- R1: A descriptor is four little-endian 32-bit words at its address. Word 0 is command/status and holds the ownership flag in bit 31 (1 = owned by the engine). Word 1 bits 15:0 hold the stored byte count and bits 31:16 hold the buffer size. Word 2 is the buffer address and word 3 is the next-descriptor address.
- R2: Rings are searched in ascending index order, 0 first. A ring whose working pointer is zero is skipped.
- R3: Within a ring the search starts at the working pointer and follows the next links. It leaves the ring once a next link equals the ring's head pointer, or after HOP_LIMIT descriptors.
- R4: The frame goes into the first descriptor met that is owned and whose buffer size is greater than or equal to the frame length, and into that descriptor only.
- R5: Byte k of the frame is written to buffer address + offset + k. The offset is 2 when bit 28 of the configuration register (offset 0x408) was last written as 1, and 0 otherwise (also after reset).
- R6: After the frame is stored, word 1 bits 15:0 become length + offset with bits 31:16 unchanged, and word 0 gets bit 31 cleared with its other bits kept. The ring's working pointer then moves to that descriptor's next address, so the ring's next frame uses the next descriptor.
- R7: A write to a ring-pointer register (offset 0x4A0 + 4*ring) loads both that ring's head pointer and its working pointer. A read returns the head pointer.
- R8: The four start-pointer registers at 0x480 + 4*ring are plain read/write storage and do not affect the engine.
- R9: The cause register (0x450) takes old AND write data on a write, and bit 0 is set when a frame is stored. If both happen in the same cycle, bit 0 ends up set.
- R10: The mask register is at 0x458. The irq output equals OR(cause AND mask) and changes on the same clock edge as the registers it is computed from, including a mask write.
- R11: A frame for which no descriptor fits has all its bytes taken from the stream. It causes no memory write and leaves the cause register unchanged, and the engine then accepts the next frame.
- R12: Once raised, a memory request keeps its address and data stable until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = word read |
| mem_byte | output | 1 | 1 = single byte write of mem_wdata[7:0] at mem_addr |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| frm_len_valid | input | 1 | Frame length valid |
| frm_len | input | 16 | Frame length in bytes |
| frm_len_ready | output | 1 | Engine accepts a new frame length |
| frm_valid | input | 1 | Frame byte valid |
| frm_byte | input | 8 | Frame byte |
| frm_ready | output | 1 | Engine accepts a frame byte |
| irq | output | 1 | Level receive interrupt |

## Verification
Two actions can hit the cause register in the same cycle: software clearing it with an AND-write, and the engine setting bit 0 when a stored frame completes. The bench provokes this by writing zero to the cause register on every cycle while a frame is being processed. It stops at the first cycle in which the engine is idle again, so the last clearing write lands in the same cycle as the completion. Bit 0 must then read back as 1 and irq must be high, because a lost event would leave software without a receive interrupt.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam logic [11:0] OFS_CFG   = 12'h408;
    localparam logic [11:0] OFS_CAUSE = 12'h450;
    localparam logic [11:0] OFS_MASK  = 12'h458;
    localparam logic [11:0] OFS_START = 12'h480;
    localparam logic [11:0] OFS_RING  = 12'h4A0;
    localparam int          CFG_OFF_BIT = 28;
    localparam int          OWN_BIT     = 31;

    typedef enum logic [3:0] {
        S_IDLE, S_SCAN, S_RDW, S_EVAL, S_DATA,
        S_BYTE, S_WB1, S_WB0, S_DONE, S_DROP
    } eng_state_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs import rxr_pkg::*; #(
    parameter int NRINGS = 4,
    localparam int RIW   = $clog2(NRINGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [11:0]                   reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic                          acc_valid,
    input  logic [RIW-1:0]                acc_ring,
    input  logic [31:0]                   acc_next,
    output logic [NRINGS-1:0][31:0]       cur_ptr,
    output logic [NRINGS-1:0][31:0]       head_ptr,
    output logic                          off_en,
    output logic                          irq
);
    typedef struct packed {
        logic [NRINGS-1:0][31:0] start;
        logic [NRINGS-1:0][31:0] head;
        logic [NRINGS-1:0][31:0] cur;
        logic                    off;
        logic [31:0]             cause;
        logic [31:0]             mask;
        logic                    irq;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        // engine advance first, so a software pointer load in the same cycle wins
        if (acc_valid) d.cur[acc_ring] = acc_next;
        if (reg_wr) begin
            for (int i = 0; i < NRINGS; i++) begin
                if (reg_addr == OFS_START + 12'(4 * i)) d.start[i] = reg_wdata;
                if (reg_addr == OFS_RING + 12'(4 * i)) begin
                    d.head[i] = reg_wdata;
                    d.cur[i]  = reg_wdata;
                end
            end
            if (reg_addr == OFS_CFG)   d.off   = reg_wdata[CFG_OFF_BIT];
            if (reg_addr == OFS_CAUSE) d.cause = q.cause & reg_wdata;
            if (reg_addr == OFS_MASK)  d.mask  = reg_wdata;
        end
        // a receive event is never lost to a simultaneous clearing write
        if (acc_valid) d.cause[0] = 1'b1;
        d.irq = |(d.cause & d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NRINGS; i++) begin
            if (reg_addr == OFS_START + 12'(4 * i)) reg_rdata = q.start[i];
            if (reg_addr == OFS_RING + 12'(4 * i))  reg_rdata = q.head[i];
        end
        if (reg_addr == OFS_CFG)   reg_rdata[CFG_OFF_BIT] = q.off;
        if (reg_addr == OFS_CAUSE) reg_rdata = q.cause;
        if (reg_addr == OFS_MASK)  reg_rdata = q.mask;
    end

    assign cur_ptr  = q.cur;
    assign head_ptr = q.head;
    assign off_en   = q.off;
    assign irq      = q.irq;

    // R9: a completion in the same cycle as an AND-write still leaves bit 0 set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> q.cause[0]);

    // R10: the interrupt level tracks cause AND mask
    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(q.cause & q.mask));

    for (genvar g = 0; g < NRINGS; g++) begin : g_ptr_chk
        // R7: a pointer write loads head and working pointer alike
        p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == OFS_RING + 12'(4 * g)) |=> (q.cur[g] == q.head[g]));
    end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine import rxr_pkg::*; #(
    parameter int NRINGS    = 4,
    parameter int LENW      = 16,
    parameter int HOP_LIMIT = 64,
    localparam int RIW      = $clog2(NRINGS),
    localparam int RW       = RIW + 1,
    localparam int HW       = $clog2(HOP_LIMIT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_len_valid,
    input  logic [LENW-1:0]         frm_len,
    output logic                    frm_len_ready,
    input  logic                    frm_valid,
    input  logic [7:0]              frm_byte,
    output logic                    frm_ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic                    mem_byte,
    output logic [31:0]             mem_addr,
    output logic [31:0]             mem_wdata,
    input  logic [31:0]             mem_rdata,
    input  logic                    mem_ack,
    input  logic [NRINGS-1:0][31:0] cur_ptr,
    input  logic [NRINGS-1:0][31:0] head_ptr,
    input  logic                    off_en,
    output logic                    acc_valid,
    output logic [RIW-1:0]          acc_ring,
    output logic [31:0]             acc_next
);
    typedef struct packed {
        eng_state_e      st;
        logic [LENW-1:0] len;
        logic [RW-1:0]   ring;
        logic [31:0]     daddr;
        logic [1:0]      widx;
        logic [31:0]     cmd;
        logic [31:0]     w1;
        logic [31:0]     bufa;
        logic [31:0]     nxt;
        logic [31:0]     wptr;
        logic [HW-1:0]   hops;
        logic [LENW-1:0] cnt;
        logic [7:0]      byte_q;
        logic            off;
    } eng_t;

    eng_t d, q;
    logic [RIW-1:0]  ridx;
    logic            fits;
    logic [LENW-1:0] stored_len;

    assign ridx       = q.ring[RIW-1:0];
    assign fits       = q.cmd[OWN_BIT] && (q.w1[31:16] >= 16'(q.len));
    assign stored_len = q.len + (q.off ? LENW'(2) : LENW'(0));

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: if (frm_len_valid) begin
                d.len  = frm_len;
                d.ring = '0;
                d.st   = S_SCAN;
            end
            S_SCAN: begin
                d.cnt = '0;
                if (q.ring == RW'(NRINGS)) begin
                    d.st = (q.len == '0) ? S_IDLE : S_DROP;
                end else if (cur_ptr[ridx] == '0) begin
                    d.ring = q.ring + RW'(1);
                end else begin
                    d.daddr = cur_ptr[ridx];
                    d.hops  = '0;
                    d.widx  = '0;
                    d.st    = S_RDW;
                end
            end
            S_RDW: if (mem_ack) begin
                unique case (q.widx)
                    2'd0: d.cmd  = mem_rdata;
                    2'd1: d.w1   = mem_rdata;
                    2'd2: d.bufa = mem_rdata;
                    default: d.nxt = mem_rdata;
                endcase
                d.widx = q.widx + 2'd1;
                if (q.widx == 2'd3) d.st = S_EVAL;
            end
            S_EVAL: begin
                if (fits) begin
                    d.off  = off_en;
                    d.wptr = q.bufa + (off_en ? 32'd2 : 32'd0);
                    d.cnt  = '0;
                    d.st   = (q.len == '0) ? S_WB1 : S_DATA;
                end else begin
                    d.hops = q.hops + HW'(1);
                    if (q.nxt == head_ptr[ridx] || d.hops == HW'(HOP_LIMIT)) begin
                        d.ring = q.ring + RW'(1);
                        d.st   = S_SCAN;
                    end else begin
                        d.daddr = q.nxt;
                        d.widx  = '0;
                        d.st    = S_RDW;
                    end
                end
            end
            S_DATA: if (frm_valid) begin
                d.byte_q = frm_byte;
                d.st     = S_BYTE;
            end
            S_BYTE: if (mem_ack) begin
                d.wptr = q.wptr + 32'd1;
                d.cnt  = q.cnt + LENW'(1);
                d.st   = (d.cnt == q.len) ? S_WB1 : S_DATA;
            end
            S_WB1: if (mem_ack) d.st = S_WB0;
            S_WB0: if (mem_ack) d.st = S_DONE;
            S_DONE: d.st = S_IDLE;
            S_DROP: if (frm_valid) begin
                d.cnt = q.cnt + LENW'(1);
                if (d.cnt == q.len) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        frm_len_ready = (q.st == S_IDLE);
        frm_ready     = (q.st == S_DATA) || (q.st == S_DROP);
        mem_req       = (q.st == S_RDW) || (q.st == S_BYTE) || (q.st == S_WB1) || (q.st == S_WB0);
        mem_we        = (q.st != S_RDW);
        mem_byte      = (q.st == S_BYTE);
        mem_addr      = q.daddr;
        mem_wdata     = '0;
        unique case (q.st)
            S_RDW:  mem_addr = q.daddr + {28'd0, q.widx, 2'b00};
            S_BYTE: begin
                mem_addr  = q.wptr;
                mem_wdata = {24'd0, q.byte_q};
            end
            S_WB1: begin
                mem_addr  = q.daddr + 32'd4;
                mem_wdata = {q.w1[31:16], 16'(stored_len)};
            end
            S_WB0: mem_wdata = q.cmd & ~(32'd1 << OWN_BIT);
            default: ;
        endcase
        acc_valid = (q.st == S_DONE);
        acc_ring  = ridx;
        acc_next  = q.nxt;
    end

    // R12: an outstanding request is held steady until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R11: a dropped frame produces no memory traffic
    p_drop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DROP) |-> !mem_req);

    // R11: length and byte streams are never accepted at once
    p_stream_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_len_ready && frm_ready));

    // R4: a count is written back only into a descriptor large enough
    p_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WB1) |-> (q.w1[31:16] >= 16'(q.len)));
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma import rxr_pkg::*; #(
    parameter int NRINGS    = 4,
    parameter int LENW      = 16,
    parameter int HOP_LIMIT = 64,
    localparam int RIW      = $clog2(NRINGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [11:0]     reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_byte,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    input  logic            frm_len_valid,
    input  logic [LENW-1:0] frm_len,
    output logic            frm_len_ready,
    input  logic            frm_valid,
    input  logic [7:0]      frm_byte,
    output logic            frm_ready,
    output logic            irq
);
    logic [NRINGS-1:0][31:0] cur_ptr;
    logic [NRINGS-1:0][31:0] head_ptr;
    logic                    off_en;
    logic                    acc_valid;
    logic [RIW-1:0]          acc_ring;
    logic [31:0]             acc_next;

    rxr_regs #(.NRINGS(NRINGS)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_ring(acc_ring), .acc_next(acc_next),
        .cur_ptr(cur_ptr), .head_ptr(head_ptr), .off_en(off_en), .irq(irq)
    );

    rxr_engine #(.NRINGS(NRINGS), .LENW(LENW), .HOP_LIMIT(HOP_LIMIT)) i_engine (
        .clk(clk), .rst_n(rst_n),
        .frm_len_valid(frm_len_valid), .frm_len(frm_len), .frm_len_ready(frm_len_ready),
        .frm_valid(frm_valid), .frm_byte(frm_byte), .frm_ready(frm_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cur_ptr(cur_ptr), .head_ptr(head_ptr), .off_en(off_en),
        .acc_valid(acc_valid), .acc_ring(acc_ring), .acc_next(acc_next)
    );
endmodule

// File: tb/test_rxring_dma.sv
`timescale 1ns/1ps
module test_rxring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_byte;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        frm_len_valid = 1'b0;
    logic [15:0] frm_len = '0;
    logic        frm_len_ready;
    logic        frm_valid = 1'b0;
    logic [7:0]  frm_byte = '0;
    logic        frm_ready;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int n_writes = 0;
    int proto_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rxring_dma i_rxring_dma (.*);

    // memory model: acknowledges one cycle after a request
    logic [7:0] mem [0:8191];
    logic        prev_req = 1'b0, prev_ack = 1'b0;
    logic [31:0] prev_addr = '0, prev_wdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                n_writes <= n_writes + 1;
                if (mem_byte) mem[mem_addr[12:0]] <= mem_wdata[7:0];
                else for (int k = 0; k < 4; k++) mem[mem_addr[12:0] + 13'(k)] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= {mem[mem_addr[12:0] + 13'd3], mem[mem_addr[12:0] + 13'd2],
                              mem[mem_addr[12:0] + 13'd1], mem[mem_addr[12:0]]};
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (rst_n && prev_req && !prev_ack &&
            (!mem_req || mem_addr != prev_addr || mem_wdata != prev_wdata))
            proto_err <= proto_err + 1;
        prev_req   <= mem_req;
        prev_ack   <= mem_ack;
        prev_addr  <= mem_addr;
        prev_wdata <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic put_w(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[13'(a + k)] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] get_w(input int a);
        return {mem[13'(a + 3)], mem[13'(a + 2)], mem[13'(a + 1)], mem[13'(a)]};
    endfunction

    task automatic put_desc(input int a, input logic [31:0] cmd, input int size, input int bufa, input int nxt);
        put_w(a, cmd);
        put_w(a + 4, {16'(size), 16'd0});
        put_w(a + 8, 32'(bufa));
        put_w(a + 12, 32'(nxt));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 8192; i++) mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        @(negedge clk);
        frm_len_valid = 1'b1; frm_len = 16'(len);
        while (!frm_len_ready) @(negedge clk);
        @(negedge clk);
        frm_len_valid = 1'b0;
        for (int k = 0; k < len; k++) begin
            frm_valid = 1'b1; frm_byte = seed + 8'(k);
            while (!frm_ready) @(negedge clk);
            @(negedge clk);
        end
        frm_valid = 1'b0;
        while (!frm_len_ready) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk_eq("R10 irq after reset", 32'(irq), 0);
        rd(12'h450, v); chk_eq("R9 cause after reset", v, 0);
        rd(12'h458, v); chk_eq("R10 mask after reset", v, 0);
        rd(12'h4A0, v); chk_eq("R7 ring pointer after reset", v, 0);
        chk_eq("R11 ready for a frame after reset", 32'(frm_len_ready), 1);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        do_reset();
        put_desc(32'h100, 32'h8000_005A, 64, 32'h400, 32'h110);
        put_desc(32'h110, 32'h8000_0000, 64, 32'h500, 32'h100);
        wr(12'h458, 32'h1);
        wr(12'h4A0, 32'h100);
        send_frame(10, 8'h30);
        for (int k = 0; k < 10; k++) chk_eq("R1 R4 frame byte in buffer", 32'(mem[13'(32'h400 + k)]), 32'(8'h30 + 8'(k)));
        chk_eq("R4 byte past frame untouched", 32'(mem[13'h40A]), 32'hEE);
        chk_eq("R6 count word", get_w(32'h104), {16'd64, 16'd10});
        chk_eq("R6 ownership cleared, other bits kept", get_w(32'h100), 32'h0000_005A);
        chk_eq("R4 second descriptor untouched", get_w(32'h110), 32'h8000_0000);
        rd(12'h450, v); chk_eq("R9 cause bit set", v, 1);
        chk_eq("R10 irq raised", 32'(irq), 1);
        wr(12'h450, 32'h0);
        rd(12'h450, v); chk_eq("R9 AND-write clears", v, 0);
        chk_eq("R10 irq drops", 32'(irq), 0);
        send_frame(3, 8'h70);
        chk_eq("R6 next frame uses next descriptor", 32'(mem[13'h500]), 32'h70);
        chk_eq("R6 next descriptor count", get_w(32'h114), {16'd64, 16'd3});
    endtask

    task automatic t_offset();
        logic [31:0] v;
        do_reset();
        wr(12'h408, 32'h1000_0000);
        rd(12'h408, v); chk_eq("R5 config readback", v, 32'h1000_0000);
        put_desc(32'h100, 32'h8000_0000, 16, 32'h400, 32'h100);
        wr(12'h4A0, 32'h100);
        send_frame(5, 8'h11);
        chk_eq("R5 offset bytes untouched", {16'd0, mem[13'h401], mem[13'h400]}, 32'h0000_EEEE);
        chk_eq("R5 first byte at buffer+2", 32'(mem[13'h402]), 32'h11);
        chk_eq("R5 last byte at buffer+6", 32'(mem[13'h406]), 32'h15);
        chk_eq("R6 count includes offset", get_w(32'h104), {16'd16, 16'd7});
    endtask

    task automatic t_order();
        logic [31:0] v;
        do_reset();
        put_desc(32'h200, 32'h8000_0000, 32, 32'h600, 32'h210);
        put_desc(32'h210, 32'h8000_0000, 32, 32'h680, 32'h200);
        put_desc(32'h300, 32'h8000_0000, 32, 32'h700, 32'h300);
        wr(12'h4A4, 32'h200);
        wr(12'h4A8, 32'h300);
        send_frame(4, 8'hA0);
        chk_eq("R2 zero ring skipped, ring 1 used", 32'(mem[13'h600]), 32'hA0);
        chk_eq("R2 ring 2 left owned", get_w(32'h300), 32'h8000_0000);
        rd(12'h4A4, v); chk_eq("R7 read returns head, not working pointer", v, 32'h200);
        send_frame(2, 8'hB0);
        chk_eq("R7 working pointer advanced in ring 1", 32'(mem[13'h680]), 32'hB0);
    endtask

    task automatic t_fit();
        do_reset();
        put_desc(32'h100, 32'h8000_0000, 7, 32'h400, 32'h110);
        put_desc(32'h110, 32'h0000_0000, 64, 32'h500, 32'h120);
        put_desc(32'h120, 32'h8000_0000, 8, 32'h800, 32'h100);
        wr(12'h4A0, 32'h100);
        send_frame(8, 8'h40);
        chk_eq("R4 too-small descriptor kept", get_w(32'h100), 32'h8000_0000);
        chk_eq("R4 unowned descriptor not used", 32'(mem[13'h500]), 32'hEE);
        chk_eq("R4 exact-size descriptor used", 32'(mem[13'h807]), 32'h47);
        chk_eq("R4 exact-size count", get_w(32'h124), {16'd8, 16'd8});
    endtask

    task automatic t_stop();
        do_reset();
        put_desc(32'h100, 32'h0, 64, 32'h400, 32'h110);
        put_desc(32'h110, 32'h0, 64, 32'h480, 32'h100);
        put_desc(32'h200, 32'h8000_0000, 64, 32'h600, 32'h200);
        wr(12'h4A0, 32'h100);
        wr(12'h4A4, 32'h200);
        send_frame(3, 8'h55);
        chk_eq("R3 search leaves ring 0 at head, ring 1 used", 32'(mem[13'h602]), 32'h57);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        int w0;
        do_reset();
        put_desc(32'h100, 32'h8000_0000, 2, 32'h400, 32'h100);
        wr(12'h458, 32'h1);
        wr(12'h4A0, 32'h100);
        w0 = n_writes;
        send_frame(6, 8'h20);
        chk_eq("R11 no memory write on drop", 32'(n_writes - w0), 0);
        rd(12'h450, v); chk_eq("R11 cause unchanged on drop", v, 0);
        chk_eq("R11 irq stays low", 32'(irq), 0);
        send_frame(2, 8'h90);
        chk_eq("R11 next frame accepted after drop", get_w(32'h104), {16'd2, 16'd2});
    endtask

    task automatic t_start_regs();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) wr(12'h480 + 12'(4 * i), 32'hC0DE_0000 + 32'(i));
        for (int i = 0; i < 4; i++) begin
            rd(12'h480 + 12'(4 * i), v);
            chk_eq("R8 start pointer storage", v, 32'hC0DE_0000 + 32'(i));
        end
        put_desc(32'h100, 32'h8000_0000, 8, 32'h400, 32'h100);
        wr(12'h4A0, 32'h100);
        send_frame(1, 8'h66);
        chk_eq("R8 start pointers do not steer the engine", 32'(mem[13'h400]), 32'h66);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        do_reset();
        put_desc(32'h100, 32'h8000_0000, 8, 32'h400, 32'h100);
        wr(12'h4A0, 32'h100);
        send_frame(2, 8'h01);
        rd(12'h450, v); chk_eq("R10 cause set while masked", v, 1);
        chk_eq("R10 irq low while masked", 32'(irq), 0);
        wr(12'h458, 32'h1);
        chk_eq("R10 irq rises on mask write", 32'(irq), 1);
        wr(12'h458, 32'h0);
        chk_eq("R10 irq falls on mask clear", 32'(irq), 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        do_reset();
        put_desc(32'h100, 32'h8000_0000, 8, 32'h400, 32'h100);
        wr(12'h458, 32'h1);
        wr(12'h4A0, 32'h100);
        fork
            send_frame(4, 8'h10);
            begin
                while (frm_len_ready) @(negedge clk);
                reg_wr = 1'b1; reg_addr = 12'h450; reg_wdata = 32'h0;
                while (!frm_len_ready) @(negedge clk);
                reg_wr = 1'b0;
            end
        join
        rd(12'h450, v); chk_eq("R9 set wins over same-cycle clear", v, 1);
        chk_eq("R9 irq high after collision", 32'(irq), 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_offset();
        t_order();
        t_fit();
        t_stop();
        t_drop();
        t_start_regs();
        t_mask();
        t_collide();
        chk_eq("R12 request held until acknowledged", 32'(proto_err), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule